// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This block takes the instruction at the source of a recorded control-flow change and produces a type mask for it. The mask has one bit for the branch class and one bit for the privilege level of the target. The caller has already fetched the leading opcode bytes and the ModRM byte. It has also worked out whether the near-call displacement is zero, whether the fetch succeeded, and the privilege levels of the source and target addresses. All of these arrive in one beat, together with a valid strobe.

Classification follows a fixed priority. A zero address gives an empty mask. The abort flag comes next, then a failed fetch, then the opcode lookup. After the lookup, a ring-transition rule runs: a jump from user to kernel space that was not caused by a system-call or software-interrupt instruction must be an interrupt, trap or fault, so its class is replaced. Any non-empty result then gets the target privilege bit. The result is registered, so it appears one cycle after the valid input.

Top module: `brc_classifier`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `type_mask` is all zeros.
- R2: If `src_addr_zero` or `dst_addr_zero` is set, the mask is all zeros, whatever the other inputs are.
- R3: If neither address is zero and `abort_flag` is set, the mask is bit 12 (abort) plus the target privilege bit, and no decode takes place.
- R4: If neither address is zero, `abort_flag` is clear and `bytes_ok` is 0, the mask is exactly bit 12.
- R5: With first byte 0x0F, a second byte of 0x05 or 0x34 gives bit 4 (syscall), 0x07 or 0x35 gives bit 5 (sysret), and 0x80..0x8F gives bit 8 (conditional). Any other second byte gives no class.
- R6: Single-byte opcodes are classified as follows. 0x70..0x7F and 0xE0..0xE3 give bit 8 (conditional). 0xC2, 0xC3, 0xCA and 0xCB give bit 3 (return). 0xCF gives bit 7 (interrupt return). 0xCC..0xCE give bit 6 (software interrupt). 0xE9..0xEB give bit 9 (jump).
- R7: Opcode 0xE8 gives bit 15 (zero-length call) when `imm_is_zero` is set, and bit 2 (call) otherwise. Opcode 0x9A gives bit 2.
- R8: For opcode 0xFF, the ModRM reg field (bits [5:3]) selects the class: 2 or 3 gives bit 11 (indirect call), 4 or 5 gives bit 17 (indirect jump), and any other value gives no class.
- R9: Any opcode not listed above gives no class. If no class results, the mask is all zeros and carries no privilege bit.
- R10: When the source is user (`src_kernel`=0), the target is kernel (`dst_kernel`=1), and the decoded class is neither syscall nor software interrupt, the class becomes bit 10 (interrupt/fault). This also applies when decode found no class.
- R11: A non-empty result also carries bit 0 when the target is user, or bit 1 when the target is kernel. Never both.
- R12: `out_valid` equals `in_valid` delayed by one cycle. The mask loads only on a valid cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The inputs on this cycle are to be classified |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Byte following an 0x0F escape |
| modrm | input | 8 | ModRM byte |
| imm_is_zero | input | 1 | The rel32 immediate of the near call is zero |
| bytes_ok | input | 1 | The opcode bytes were fetched successfully |
| abort_flag | input | 1 | The record is a transaction abort |
| src_addr_zero | input | 1 | The source address is zero |
| dst_addr_zero | input | 1 | The target address is zero |
| src_kernel | input | 1 | The source is in kernel space |
| dst_kernel | input | 1 | The target is in kernel space |
| out_valid | output | 1 | Registered valid |
| type_mask | output | 18 | Registered class and privilege mask |

## Verification
The block has no size parameters, so the bench builds it at its single configuration, where an exhaustive sweep is cheap. Every first opcode byte is combined with every ModRM reg value, both immediate states and all four source/target privilege pairs. A second sweep covers all 256 bytes after the escape byte. This reaches every table boundary, and every class meets the ring-transition rule. Directed passes cover the three early exits and how they rank against each other. A final pass holds valid low and changes the inputs, to check that the output stays as it was.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int OPC_W  = 8;
    localparam int MASK_W = 18;
    localparam int REG_LO = 3;
    localparam int REG_HI = 5;

    localparam int BT_USER      = 0;
    localparam int BT_KERNEL    = 1;
    localparam int BT_CALL      = 2;
    localparam int BT_RET       = 3;
    localparam int BT_SYSCALL   = 4;
    localparam int BT_SYSRET    = 5;
    localparam int BT_INT       = 6;
    localparam int BT_IRET      = 7;
    localparam int BT_JCC       = 8;
    localparam int BT_JMP       = 9;
    localparam int BT_IRQ       = 10;
    localparam int BT_IND_CALL  = 11;
    localparam int BT_ABORT     = 12;
    localparam int BT_IN_TX     = 13;
    localparam int BT_NO_TX     = 14;
    localparam int BT_ZERO_CALL = 15;
    localparam int BT_CSTACK    = 16;
    localparam int BT_IND_JMP   = 17;

    typedef logic [MASK_W-1:0] brtype_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef struct packed {
        opc_t first;
        opc_t second;
        logic [REG_HI-REG_LO:0] reg_field;
        logic imm_zero;
    } insn_view_t;

    typedef struct packed {
        logic addr_zero;
        logic abort;
        logic fetch_ok;
        logic src_kernel;
        logic dst_kernel;
    } xfer_ctx_t;

    function automatic brtype_t bt_bit(input int pos);
        brtype_t m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

    function automatic brtype_t priv_bit(input logic kernel);
        return kernel ? bt_bit(BT_KERNEL) : bt_bit(BT_USER);
    endfunction

endpackage

// File: rtl/brc_opcode_decode.sv
module brc_opcode_decode
    import brc_pkg::*;
(
    input  insn_view_t insn,
    output brtype_t    cls
);
    brtype_t esc_cls;
    brtype_t grp_cls;

    always_comb begin
        case (insn.second) inside
            8'h05, 8'h34:   esc_cls = bt_bit(BT_SYSCALL);
            8'h07, 8'h35:   esc_cls = bt_bit(BT_SYSRET);
            [8'h80:8'h8F]:  esc_cls = bt_bit(BT_JCC);
            default:        esc_cls = '0;
        endcase
    end

    always_comb begin
        case (insn.reg_field)
            3'd2, 3'd3: grp_cls = bt_bit(BT_IND_CALL);
            3'd4, 3'd5: grp_cls = bt_bit(BT_IND_JMP);
            default:    grp_cls = '0;
        endcase
    end

    always_comb begin
        case (insn.first) inside
            8'h0F:                        cls = esc_cls;
            [8'h70:8'h7F], [8'hE0:8'hE3]: cls = bt_bit(BT_JCC);
            8'hC2, 8'hC3, 8'hCA, 8'hCB:   cls = bt_bit(BT_RET);
            8'hCF:                        cls = bt_bit(BT_IRET);
            [8'hCC:8'hCE]:                cls = bt_bit(BT_INT);
            8'hE8:                        cls = insn.imm_zero ? bt_bit(BT_ZERO_CALL)
                                                              : bt_bit(BT_CALL);
            8'h9A:                        cls = bt_bit(BT_CALL);
            [8'hE9:8'hEB]:                cls = bt_bit(BT_JMP);
            8'hFF:                        cls = grp_cls;
            default:                      cls = '0;
        endcase
    end

    always_comb begin
        a_r9_decode_single: assert ($countones(cls) <= 1);
    end
endmodule

// File: rtl/brc_priv_merge.sv
module brc_priv_merge
    import brc_pkg::*;
(
    input  xfer_ctx_t ctx,
    input  brtype_t   cls,
    output brtype_t   result
);
    logic    ring_up;
    logic    gate_kept;
    brtype_t ring_cls;

    assign ring_up   = !ctx.src_kernel && ctx.dst_kernel;
    assign gate_kept = cls[BT_SYSCALL] || cls[BT_INT];

    always_comb begin
        ring_cls = cls;
        if (ring_up && !gate_kept)
            ring_cls = bt_bit(BT_IRQ);
    end

    always_comb begin
        if (ctx.addr_zero)
            result = '0;
        else if (ctx.abort)
            result = bt_bit(BT_ABORT) | priv_bit(ctx.dst_kernel);
        else if (!ctx.fetch_ok)
            result = bt_bit(BT_ABORT);
        else if (ring_cls == '0)
            result = '0;
        else
            result = ring_cls | priv_bit(ctx.dst_kernel);
    end

    always_comb begin
        a_r10_one_class: assert ($countones(result[MASK_W-1:2]) <= 1);
        a_r11_one_priv:  assert ($onehot0(result[1:0]));
    end
endmodule

// File: rtl/brc_classifier.sv
module brc_classifier
    import brc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  op_first,
    input  logic [OPC_W-1:0]  op_second,
    input  logic [OPC_W-1:0]  modrm,
    input  logic              imm_is_zero,
    input  logic              bytes_ok,
    input  logic              abort_flag,
    input  logic              src_addr_zero,
    input  logic              dst_addr_zero,
    input  logic              src_kernel,
    input  logic              dst_kernel,
    output logic              out_valid,
    output logic [MASK_W-1:0] type_mask
);
    insn_view_t insn;
    xfer_ctx_t  ctx;
    brtype_t    cls;
    brtype_t    next_mask;
    logic       unused_modrm;

    assign unused_modrm = ^{modrm[OPC_W-1:REG_HI+1], modrm[REG_LO-1:0]};

    assign insn = '{first: op_first, second: op_second,
                    reg_field: modrm[REG_HI:REG_LO], imm_zero: imm_is_zero};
    assign ctx  = '{addr_zero: src_addr_zero || dst_addr_zero, abort: abort_flag,
                    fetch_ok: bytes_ok, src_kernel: src_kernel, dst_kernel: dst_kernel};

    brc_opcode_decode u_decode (.insn(insn), .cls(cls));
    brc_priv_merge    u_merge  (.ctx(ctx), .cls(cls), .result(next_mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            type_mask <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                type_mask <= next_mask;
        end
    end

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r12_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r12_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(type_mask));
    a_r2_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (src_addr_zero || dst_addr_zero)) |=> (type_mask == '0));
    a_r3_abort_tag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_addr_zero && !dst_addr_zero && abort_flag)
        |=> (type_mask[BT_ABORT] && $countones(type_mask) == 2));
    a_r11_priv_pair: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(type_mask[1:0]));
endmodule

// File: tb/brc_classifier_tb.sv
module brc_classifier_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  op_first, op_second, modrm;
    logic        imm_is_zero, bytes_ok, abort_flag;
    logic        src_addr_zero, dst_addr_zero, src_kernel, dst_kernel;
    logic        out_valid;
    logic [17:0] type_mask;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    brc_classifier u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_first(op_first), .op_second(op_second), .modrm(modrm),
        .imm_is_zero(imm_is_zero), .bytes_ok(bytes_ok), .abort_flag(abort_flag),
        .src_addr_zero(src_addr_zero), .dst_addr_zero(dst_addr_zero),
        .src_kernel(src_kernel), .dst_kernel(dst_kernel),
        .out_valid(out_valid), .type_mask(type_mask)
    );

    function automatic logic [17:0] one(input int p);
        return 18'(1) << p;
    endfunction

    function automatic logic [17:0] model(
        input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
        input logic iz, input logic ok, input logic ab,
        input logic fz, input logic tz, input logic sk, input logic dk);
        logic [17:0] c, plm;
        int r;
        plm = dk ? one(1) : one(0);
        if (fz || tz) return '0;
        if (ab) return one(12) | plm;
        if (!ok) return one(12);
        c = '0;
        r = int'(m[5:3]);
        if (a == 8'h0F) begin
            if (b == 8'h05 || b == 8'h34) c = one(4);
            else if (b == 8'h07 || b == 8'h35) c = one(5);
            else if (b >= 8'h80 && b <= 8'h8F) c = one(8);
        end else if ((a >= 8'h70 && a <= 8'h7F) || (a >= 8'hE0 && a <= 8'hE3)) c = one(8);
        else if (a == 8'hC2 || a == 8'hC3 || a == 8'hCA || a == 8'hCB) c = one(3);
        else if (a == 8'hCF) c = one(7);
        else if (a >= 8'hCC && a <= 8'hCE) c = one(6);
        else if (a == 8'hE8) c = iz ? one(15) : one(2);
        else if (a == 8'h9A) c = one(2);
        else if (a >= 8'hE9 && a <= 8'hEB) c = one(9);
        else if (a == 8'hFF) begin
            if (r == 2 || r == 3) c = one(11);
            else if (r == 4 || r == 5) c = one(17);
        end
        if (!sk && dk && c != one(4) && c != one(6)) c = one(10);
        if (c != '0) c = c | plm;
        return c;
    endfunction

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %05h expected %05h (op %02h %02h modrm %02h)",
                     req, got, exp, op_first, op_second, modrm);
        end
    endtask

    task automatic run_one(input string req,
        input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
        input logic iz, input logic ok, input logic ab,
        input logic fz, input logic tz, input logic sk, input logic dk);
        in_valid = 1'b1; op_first = a; op_second = b; modrm = m;
        imm_is_zero = iz; bytes_ok = ok; abort_flag = ab;
        src_addr_zero = fz; dst_addr_zero = tz; src_kernel = sk; dst_kernel = dk;
        @(posedge clk);
        @(negedge clk);
        check(req, type_mask, model(a, b, m, iz, ok, ab, fz, tz, sk, dk));
    endtask

    function automatic string tag_for(input logic [7:0] a, input logic sk,
                                      input logic dk, input logic [17:0] e);
        if (!sk && dk) return "R10";
        if (a == 8'h0F) return "R5";
        if (a == 8'hE8 || a == 8'h9A) return "R7";
        if (a == 8'hFF) return "R8";
        if (e == '0) return "R9";
        return "R6";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_first = 8'h00; op_second = 8'h00;
        modrm = 8'h00; imm_is_zero = 1'b0; bytes_ok = 1'b1; abort_flag = 1'b0;
        src_addr_zero = 1'b0; dst_addr_zero = 1'b0; src_kernel = 1'b0; dst_kernel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {type_mask[17:1], out_valid}, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {type_mask[17:1], out_valid}, '0);

        // R6 R7 R8 R9 R10 R11: full first-byte sweep
        for (int a = 0; a < 256; a++)
            for (int r = 0; r < 8; r++)
                for (int iz = 0; iz < 2; iz++)
                    for (int p = 0; p < 4; p++) begin
                        logic [7:0] mm;
                        logic [7:0] bb;
                        mm = {2'b01, 3'(r), 3'b110};
                        bb = 8'(a) ^ 8'h5A;
                        run_one(tag_for(8'(a), p[1], p[0],
                                        model(8'(a), bb, mm, iz[0], 1'b1, 1'b0, 1'b0, 1'b0, p[1], p[0])),
                                8'(a), bb, mm, iz[0], 1'b1, 1'b0, 1'b0, 1'b0, p[1], p[0]);
                    end

        // R5: escape byte sweep
        for (int b = 0; b < 256; b++)
            for (int p = 0; p < 4; p++)
                run_one((!p[1] && p[0]) ? "R10" : "R5", 8'h0F, 8'(b), 8'h00,
                        1'b0, 1'b1, 1'b0, 1'b0, 1'b0, p[1], p[0]);

        // R2: zero address beats abort and fetch failure
        for (int k = 0; k < 32; k++)
            run_one("R2", 8'hC3, 8'h05, 8'h10, k[0], k[1], k[2],
                    (k[4:3] != 2'b00) ? k[3] : 1'b1, k[4], k[3], k[2]);

        // R3: abort with each privilege pair, no decode
        for (int p = 0; p < 4; p++)
            run_one("R3", 8'hE8, 8'h00, 8'h00, 1'b1, p[0], 1'b1, 1'b0, 1'b0, p[1], p[0]);

        // R4: fetch failure gives bare abort
        for (int p = 0; p < 4; p++)
            run_one("R4", 8'hCC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, p[1], p[0]);

        // R11: explicit privilege bit on a return
        run_one("R11", 8'hC3, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R11", type_mask, one(3) | one(0));
        run_one("R11", 8'hC3, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R11", type_mask, one(3) | one(1));

        // R12: latency and hold while invalid
        run_one("R12", 8'hE9, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R12", {17'd0, out_valid}, 18'd1);
        in_valid = 1'b0; op_first = 8'hCF; src_kernel = 1'b1; dst_kernel = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R12", {type_mask[17:1], out_valid}, (one(9) | one(0)) & ~18'd1 | {17'd0, 1'b0});
            check("R12", {17'd0, type_mask[0]}, 18'd1);
            op_first = 8'(8'h70 + k);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule